// File: doc/BRIEF.md
# UART Receive Event and Interrupt Controller

This block sits next to a UART receiver and transmitter and turns their per-character status strobes into sticky event flags plus one maskable interrupt line. On the receive side it counts stored characters into fixed-size buffers. A buffer is closed, and an event raised, when it fills, when a character arrives with a framing error, or when the line has stayed quiet for a programmable number of idle character times while the buffer is only partly filled. It also reports the first idle character after line activity, the start and the end of a break condition, and received control characters that are kept out of the buffer. On the transmit side it flags completed buffers that asked for an interrupt.

Software reaches two 16-bit registers through a small synchronous port: the event register at address 0 and the mask register at address 1. Event flags are cleared by writing ones. The interrupt output goes high one cycle after any unmasked event flag is set.

Top module: `uart_evt_ctrl`

## Requirements
- R1: After reset the event register, the mask register, the read data and the interrupt output are all zero.
- R2: Event bit 0 is set when the number of stored characters in the current buffer reaches the buffer size; the count then restarts at zero. A stored character is one with `rx_valid` high and both `rx_brk` and `rx_ctl_hit` low.
- R3: With a partly filled buffer, event bit 0 is set on the idle tick that makes the number of idle ticks since the last received character equal to `max_idle`, and the count restarts. A `max_idle` of zero disables this close.
- R4: A stored character flagged with `rx_frame_err` is counted and closes the buffer at once, setting event bit 0.
- R5: Event bit 2 is set on the first idle tick after any received character; further idle ticks set nothing until another character arrives.
- R6: Event bit 3 is set by a break character received outside a break condition; later break characters set nothing until the condition ends. Event bit 4 is set when a non-break character or an idle tick ends the break condition.
- R7: Event bit 5 is set by a non-break character with `rx_ctl_hit` high; that character is not counted into the buffer.
- R8: Event bit 1 is set when `tx_done` is high together with `tx_irq_req`; `tx_done` alone sets nothing.
- R9: Writing 1 to an event bit at address 0 clears it, writing 0 leaves it unchanged, and an event arriving in the same cycle as its clear leaves the bit set.
- R10: The mask register at address 1 stores and reads back all 16 bits; event bits 15 to 6 always read zero.
- R11: `irq` equals, one cycle later, the OR over all bits of the event register ANDed with the mask register.
- R12: `reg_rdata` shows the register selected by `reg_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_frame_err | input | 1 | Received character had a framing error |
| rx_brk | input | 1 | Received character is a break character |
| rx_ctl_hit | input | 1 | Received character matches a control character kept out of the buffer |
| idle_tick | input | 1 | One full idle character time has passed on the line |
| tx_done | input | 1 | A transmit buffer has been completely sent |
| tx_irq_req | input | 1 | The finished transmit buffer asked for an interrupt |
| buf_size | input | 8 | Receive buffer size in characters, 1 or more |
| max_idle | input | 16 | Idle ticks before a partly filled buffer closes, 0 disables |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 event, 1 mask |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The checks on buffer occupancy assume that `buf_size` is at least one and does not change while characters are being counted, so the bench programs it once before releasing reset and never touches it again. The properties also take `rx_valid` and `idle_tick` to be mutually exclusive, as they are on a real line where a character and an idle character time cannot end together; every stimulus pattern drives at most one of them per cycle. The clear-versus-set property assumes that clears arrive only through writes to address 0, and the bench issues clears no other way.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int EV_W      = 16;
  localparam int EV_USED   = 6;
  localparam int EVB_RXB   = 0;
  localparam int EVB_TXD   = 1;
  localparam int EVB_IDLE  = 2;
  localparam int EVB_BRKS  = 3;
  localparam int EVB_BRKE  = 4;
  localparam int EVB_CTRL  = 5;

  typedef enum logic [0:0] {
    SEL_EVENT = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/uevt_buf_tracker.sv
module uevt_buf_tracker #(
  parameter int CNT_W  = 8,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_any,
  input  logic              chr_store,
  input  logic              chr_err,
  input  logic              idle_tick,
  input  logic [CNT_W-1:0]  buf_size,
  input  logic [IDLE_W-1:0] max_idle,
  output logic              close_now,
  output logic [CNT_W-1:0]  fill
);
  logic [CNT_W-1:0]  fill_q, fill_n;
  logic [IDLE_W-1:0] idle_q, idle_n;
  logic [CNT_W:0]    fill_inc;
  logic [IDLE_W:0]   idle_inc;

  assign fill_inc = {1'b0, fill_q} + 1'b1;
  assign idle_inc = {1'b0, idle_q} + 1'b1;

  always_comb begin
    fill_n    = fill_q;
    idle_n    = idle_q;
    close_now = 1'b0;
    if (chr_any) begin
      // any character restarts the quiet-time count
      idle_n = '0;
      if (chr_store) begin
        if (chr_err || (fill_inc >= {1'b0, buf_size})) begin
          close_now = 1'b1;
          fill_n    = '0;
        end else begin
          fill_n = fill_inc[CNT_W-1:0];
        end
      end
    end else if (idle_tick && (fill_q != '0) && (max_idle != '0)) begin
      if (idle_inc >= {1'b0, max_idle}) begin
        close_now = 1'b1;
        fill_n    = '0;
        idle_n    = '0;
      end else begin
        idle_n = idle_inc[IDLE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      idle_q <= '0;
    end else begin
      fill_q <= fill_n;
      idle_q <= idle_n;
    end
  end

  assign fill = fill_q;
endmodule

// File: rtl/uevt_line_watch.sv
module uevt_line_watch (
  input  logic clk,
  input  logic rst,
  input  logic chr_any,
  input  logic is_brk,
  input  logic is_ctl,
  input  logic idle_tick,
  output logic ev_idle,
  output logic ev_brks,
  output logic ev_brke,
  output logic ev_ctrl
);
  logic busy_q;
  logic brk_q;

  always_comb begin
    ev_ctrl = chr_any & is_ctl & ~is_brk;
    ev_brks = chr_any & is_brk & ~brk_q;
    ev_brke = brk_q & ((chr_any & ~is_brk) | (~chr_any & idle_tick));
    ev_idle = ~chr_any & idle_tick & busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
    end else if (chr_any) begin
      busy_q <= 1'b1;
      brk_q  <= is_brk;
    end else if (idle_tick) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/uevt_reg_bank.sv
module uevt_reg_bank
  import uart_evt_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int USED  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [USED-1:0]  ev_set,
  input  logic             we,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq,
  output logic [REG_W-1:0] ev_out,
  output logic [REG_W-1:0] mask_out
);
  logic [REG_W-1:0] ev_q, mask_q, clr_vec, set_vec, live;

  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_bits
      if (gi < USED) begin : g_live
        assign live[gi]    = 1'b1;
        assign set_vec[gi] = ev_set[gi];
      end else begin : g_resv
        assign live[gi]    = 1'b0;
        assign set_vec[gi] = 1'b0;
      end
    end
  endgenerate

  assign clr_vec = (we && sel == SEL_EVENT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      mask_q <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      ev_q <= ((ev_q & ~clr_vec) | set_vec) & live;
      if (we && sel == SEL_MASK) mask_q <= wdata;
      rdata <= (sel == SEL_MASK) ? mask_q : ev_q;
      irq   <= |(ev_q & mask_q);
    end
  end

  assign ev_out   = ev_q;
  assign mask_out = mask_q;
endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_frame_err,
  input  logic              rx_brk,
  input  logic              rx_ctl_hit,
  input  logic              idle_tick,
  input  logic              tx_done,
  input  logic              tx_irq_req,
  input  logic [CNT_W-1:0]  buf_size,
  input  logic [IDLE_W-1:0] max_idle,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [EV_W-1:0]   reg_wdata,
  output logic [EV_W-1:0]   reg_rdata,
  output logic              irq
);
  logic              chr_store;
  logic              close_now;
  logic [CNT_W-1:0]  fill_cnt;
  logic              ev_idle, ev_brks, ev_brke, ev_ctrl;
  logic [EV_USED-1:0] ev_set;
  logic [EV_W-1:0]   ev_vec, mask_vec;

  assign chr_store = rx_valid & ~rx_brk & ~rx_ctl_hit;

  uevt_buf_tracker #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .chr_any   (rx_valid),
    .chr_store (chr_store),
    .chr_err   (rx_frame_err),
    .idle_tick (idle_tick),
    .buf_size  (buf_size),
    .max_idle  (max_idle),
    .close_now (close_now),
    .fill      (fill_cnt)
  );

  uevt_line_watch u_line (
    .clk       (clk),
    .rst       (rst),
    .chr_any   (rx_valid),
    .is_brk    (rx_brk),
    .is_ctl    (rx_ctl_hit),
    .idle_tick (idle_tick),
    .ev_idle   (ev_idle),
    .ev_brks   (ev_brks),
    .ev_brke   (ev_brke),
    .ev_ctrl   (ev_ctrl)
  );

  always_comb begin
    ev_set            = '0;
    ev_set[EVB_RXB]   = close_now;
    ev_set[EVB_TXD]   = tx_done & tx_irq_req;
    ev_set[EVB_IDLE]  = ev_idle;
    ev_set[EVB_BRKS]  = ev_brks;
    ev_set[EVB_BRKE]  = ev_brke;
    ev_set[EVB_CTRL]  = ev_ctrl;
  end

  uevt_reg_bank #(.REG_W(EV_W), .USED(EV_USED)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ev_set   (ev_set),
    .we       (reg_we),
    .sel      (reg_sel_e'(reg_addr)),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .irq      (irq),
    .ev_out   (ev_vec),
    .mask_out (mask_vec)
  );
endmodule

// File: rtl/uart_evt_chk.sv
module uart_evt_chk #(
  parameter int CNT_W = 8,
  parameter int EVW   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_brk,
  input logic             rx_ctl_hit,
  input logic             tx_done,
  input logic             tx_irq_req,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [EVW-1:0]   reg_wdata,
  input logic [EVW-1:0]   ev,
  input logic [EVW-1:0]   mask,
  input logic             irq,
  input logic [CNT_W-1:0] fill,
  input logic [CNT_W-1:0] buf_size
);
  logic [EVW-1:0] clr_seen;
  assign clr_seen = (reg_we && !reg_addr) ? reg_wdata : '0;

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (buf_size != '0) |-> (fill < buf_size));

  assert_ctrl_event_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ctl_hit && !rx_brk) |=> ev[5]);

  assert_tx_event_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_irq_req) |=> ev[1]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ev) & ~$past(clr_seen) & ~ev) == '0));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ev[EVW-1:6] == '0);

  assert_irq_follow_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(ev & mask))));
endmodule

bind uart_evt_ctrl uart_evt_chk #(.CNT_W(CNT_W), .EVW(16)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .rx_brk     (rx_brk),
  .rx_ctl_hit (rx_ctl_hit),
  .tx_done    (tx_done),
  .tx_irq_req (tx_irq_req),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .ev         (ev_vec),
  .mask       (mask_vec),
  .irq        (irq),
  .fill       (fill_cnt),
  .buf_size   (buf_size)
);

// File: tb/sim_uart_evt_ctrl.sv
`timescale 1ns/1ps
module sim_uart_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, rx_frame_err = 0, rx_brk = 0, rx_ctl_hit = 0;
  logic        idle_tick = 0, tx_done = 0, tx_irq_req = 0;
  logic [7:0]  buf_size = 8'd3;
  logic [15:0] max_idle = 16'd2;
  logic        reg_we = 0, reg_addr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_evt_ctrl u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_brk(rx_brk), .rx_ctl_hit(rx_ctl_hit), .idle_tick(idle_tick),
    .tx_done(tx_done), .tx_irq_req(tx_irq_req), .buf_size(buf_size),
    .max_idle(max_idle), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // stimulus bits: valid, break, control, frame error, idle, tx done, tx request
  localparam logic [6:0] S_V = 7'h40, S_B = 7'h20, S_C = 7'h10, S_E = 7'h08;
  localparam logic [6:0] S_I = 7'h04, S_T = 7'h02, S_Q = 7'h01;
  localparam int NSTEP = 22;
  // buffer size 3, idle close after 2 ticks; expected newly set event bits
  localparam logic [12:0] TBL [NSTEP] = '{
    {S_V, 6'h00}, {S_V, 6'h00},
    {S_V, 6'h01},             // R2 buffer full
    {S_I, 6'h04},             // R5 first idle
    {S_I, 6'h00},             // R5 no repeat
    {S_V, 6'h00},
    {S_I, 6'h04},             // R5
    {S_I, 6'h01},             // R3 idle close
    {S_I, 6'h00},
    {S_V | S_C, 6'h20},       // R7 control char
    {S_V, 6'h00}, {S_V, 6'h00},
    {S_V | S_C, 6'h20},       // R7 not counted
    {S_V, 6'h01},             // R2 third stored char
    {S_V | S_B, 6'h08},       // R6 break start
    {S_V | S_B, 6'h00},       // R6 no repeat
    {S_V, 6'h10},             // R6 break end by char
    {S_V | S_E, 6'h01},       // R4 error close
    {S_T | S_Q, 6'h02},       // R8
    {S_T, 6'h00},             // R8 no request
    {S_V | S_B, 6'h08},       // R6
    {S_I, 6'h14}              // R6 end by idle, R5
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] s);
    {rx_valid, rx_brk, rx_ctl_hit, rx_frame_err, idle_tick, tx_done, tx_irq_req} = s;
  endtask

  task automatic pulse(input logic [6:0] s);
    @(negedge clk) drive(s);
    @(negedge clk) drive('0);
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    @(negedge clk) reg_addr = sel;
    @(negedge clk) v = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk) begin reg_we = 1; reg_addr = sel; reg_wdata = d; end
    @(negedge clk) begin reg_we = 0; reg_addr = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0);
    rd(0, v); chk("R1 event", v, 16'h0);
    rd(1, v); chk("R1 mask R12", v, 16'h0);

    for (int i = 0; i < NSTEP; i++) begin
      pulse(TBL[i][12:6]);
      rd(0, v);
      chk($sformatf("table step %0d R2 R3 R4 R5 R6 R7 R8", i), v, {10'd0, TBL[i][5:0]});
      wr(0, 16'hFFFF);
    end

    // R10 mask readback, reserved event bits
    wr(1, 16'hFFFF); rd(1, v); chk("R10 mask all", v, 16'hFFFF);
    wr(0, 16'hFFFF); rd(0, v); chk("R10 event reserved", v, 16'h0);

    // R11 irq one cycle after event
    wr(1, 16'h0002);
    @(negedge clk) drive(S_T | S_Q);
    @(negedge clk) begin drive('0); chk("R11 irq not yet", {15'd0, irq}, 16'h0); end
    @(negedge clk) chk("R11 irq high", {15'd0, irq}, 16'h1);
    wr(0, 16'hFFFF);
    @(negedge clk) chk("R11 irq low after clear", {15'd0, irq}, 16'h0);
    pulse(S_V | S_C);
    repeat (3) @(negedge clk);
    chk("R11 masked event no irq", {15'd0, irq}, 16'h0);
    wr(0, 16'hFFFF);

    // R9 set wins over clear, write 0 no effect
    @(negedge clk) begin drive(S_T | S_Q); reg_we = 1; reg_addr = 0; reg_wdata = 16'hFFFF; end
    @(negedge clk) begin drive('0); reg_we = 0; end
    rd(0, v); chk("R9 set wins", v, 16'h0002);
    wr(0, 16'h0000); rd(0, v); chk("R9 write zero keeps", v, 16'h0002);
    wr(0, 16'h0002); rd(0, v); chk("R9 write one clears", v, 16'h0000);

    // R3 max_idle zero disables idle close
    max_idle = 16'd0;
    pulse(S_V);
    for (int k = 0; k < 5; k++) pulse(S_I);
    rd(0, v); chk("R3 disabled", v, 16'h0004);
    wr(0, 16'hFFFF);
    max_idle = 16'd2;
    pulse(S_I); pulse(S_I);
    rd(0, v); chk("R3 re-enabled close", v, 16'h0001);
    wr(0, 16'hFFFF);

    // R12 read latency
    wr(1, 16'h00A5);
    @(negedge clk) reg_addr = 0;
    @(negedge clk) begin reg_addr = 1; #1 chk("R12 old select", reg_rdata, 16'h0000); end
    @(negedge clk) chk("R12 new select", reg_rdata, 16'h00A5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule